// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the per-processor timer that sits beside a local interrupt controller. Software programs three settings through a small register port: a starting count, a clock-divide selection and a timer vector entry. The vector entry holds an interrupt vector, a mask flag and a one-shot/periodic flag. A power-of-two prescaler turns the core clock into divided ticks. The count runs down once per divided tick. When it passes zero, the timer emits a one-cycle interrupt request that carries the programmed vector, unless the entry is masked. A read-only register returns the remaining count.

The register port is a plain one-cycle write strobe with a combinational read mux. It has no back-pressure. The interrupt output is a single-cycle valid pulse with an 8-bit vector and no ready. The receiving prioritisation logic must take the pulse in the cycle it appears.

Register addresses (2-bit) are: 0 for the starting count (32 bits), 1 for the divide selection (bits 3:0), 2 for the vector entry and 3 for the current count. In the vector entry, the vector sits in bits 7:0, the mask flag in bit 16 and the periodic flag in bit 17.

Top module: `loc_irq_timer`

## Requirements
- R1: After reset, the register reads are as follows: starting count 0, divide selection 0, vector entry 0x0001_0000 (masked, one-shot, vector 0) and current count 0. The interrupt output is low.
- R2: After reset and before any divide write, the prescale shift is 0, so one divided tick occurs per clock.
- R3: The divide selection code is formed from bits {3,1,0} of the divide register, and bit 2 is ignored. Code 3'b111 divides by 1. Any other code c divides by 2^(c+1). The divide register reads back bits 3:0 as written.
- R4: One-shot mode works as follows. A write of starting count N>0 takes effect at clock edge E. A single interrupt then appears after edge E+(N+1)*2^s, where s is the prescale shift. After edge E+k, the current count reads N-floor(k/2^s) until expiry and 0 afterwards.
- R5: Periodic mode works as follows. Interrupts appear after every edge E+m*(N+1)*2^s for m≥1. The current count reads N - (floor(k/2^s) mod (N+1)).
- R6: A starting count of 0 never produces an interrupt, in either mode, and the current count stays 0.
- R7: With the mask flag set, no interrupt is raised. The count still runs and reads the same values as in R4/R5.
- R8: Each interrupt is high for exactly one cycle, and the vector output equals the vector field at expiry.
- R9: A write to the starting count restarts both the count and the prescaler. If that write coincides with an expiry, the write wins: no interrupt is produced, and the count restarts from the new value.
- R10: Writes to the current-count address have no effect on any register or on the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
A reload of the starting count and an expiry can fall in the same cycle. The bench provokes this in periodic mode by timing a write so that it is sampled on exactly the edge where the count would pass zero. It judges the outcome by checking that there is no pulse in that cycle, that the current count shows the newly written value, and that the next pulse arrives a full new period later. The divide, mode, mask and count sweeps compare the pulse and the current count against arithmetic expectations in every cycle.

// File: rtl/loc_irq_timer_pkg.sv
package loc_irq_timer_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int VEC_W   = 8;
  localparam int SHIFT_W = 3;
  localparam int DIV_W   = 4;

  localparam logic [ADDR_W-1:0] A_START = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 2'd1;
  localparam logic [ADDR_W-1:0] A_VENT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CUR   = 2'd3;

  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vector;
  } vent_t;

  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] d);
    logic [2:0] code;
    code = {d[3], d[1:0]};
    if (code == 3'b111) return '0;
    return SHIFT_W'(code) + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/loc_irq_timer_prescaler.sv
module loc_irq_timer_prescaler
  import loc_irq_timer_pkg::*;
#(
  parameter int SW = SHIFT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic [SW-1:0] shift_i,
  output logic          tick_o
);
  localparam int PRE_W = (1 << SW) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   lim_m1;

  assign lim_m1 = ((PRE_W+1)'(1) << shift_i) - (PRE_W+1)'(1);
  assign tick_o = ({1'b0, pre_q} >= lim_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)        pre_q <= '0;
    else if (clear_i)  pre_q <= '0;
    else if (tick_o)   pre_q <= '0;
    else               pre_q <= pre_q + PRE_W'(1);
  end

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (pre_q == '0));

  // R3
  prescale_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !tick_o) |=> (pre_q == $past(pre_q) + PRE_W'(1)));
endmodule

// File: rtl/loc_irq_timer_regs.sv
module loc_irq_timer_regs
  import loc_irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cur_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  start_q,
  output logic [SHIFT_W-1:0] shift_q,
  output vent_t             vent_q
);
  logic [DIV_W-1:0] div_q;

  assign load_o     = wr_en && (wr_addr == A_START);
  assign load_val_o = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      div_q   <= '0;
      shift_q <= '0;
      vent_q  <= '{periodic: 1'b0, mask: 1'b1, vector: '0};
    end else if (wr_en) begin
      case (wr_addr)
        A_START: start_q <= load_val_o;
        A_DIV: begin
          div_q   <= wr_data[DIV_W-1:0];
          shift_q <= div_to_shift(wr_data[DIV_W-1:0]);
        end
        A_VENT: vent_q <= '{periodic: wr_data[PER_BIT], mask: wr_data[MASK_BIT],
                            vector: wr_data[VEC_W-1:0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_START: rd_data[CNT_W-1:0] = start_q;
      A_DIV:   rd_data[DIV_W-1:0] = div_q;
      A_VENT: begin
        rd_data[VEC_W-1:0] = vent_q.vector;
        rd_data[MASK_BIT]  = vent_q.mask;
        rd_data[PER_BIT]   = vent_q.periodic;
      end
      default: rd_data[CNT_W-1:0] = cur_i;
    endcase
  end

  // R9
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (start_q == $past(load_val_o)));

  // R10
  cur_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CUR) |=> ($stable(start_q) && $stable(div_q) && $stable(vent_q)));
endmodule

// File: rtl/loc_irq_timer_countdown.sv
module loc_irq_timer_countdown
  import loc_irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             tick_i,
  input  vent_t            vent_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             irq_valid_o,
  output logic [VEC_W-1:0] irq_vector_o
);
  logic armed, done_q, expire;

  assign armed  = (start_i != '0);
  assign expire = !load_i && tick_i && armed && (cur_o == '0) &&
                  (vent_i.periodic || !done_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_o  <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      cur_o  <= load_val_i;
      done_q <= 1'b0;
    end else if (tick_i && armed) begin
      if (vent_i.periodic) begin
        done_q <= 1'b0;
        cur_o  <= (cur_o == '0) ? start_i : cur_o - CNT_W'(1);
      end else if (!done_q) begin
        if (cur_o == '0) done_q <= 1'b1;
        else             cur_o  <= cur_o - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid_o  <= 1'b0;
      irq_vector_o <= '0;
    end else begin
      irq_valid_o <= expire && !vent_i.mask;
      if (expire) irq_vector_o <= vent_i.vector;
    end
  end

  // R5
  cur_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_o <= start_i);

  // R4
  oneshot_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !vent_i.periodic) |-> (cur_o == '0));

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> !$past(vent_i.mask));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |=> !irq_valid_o);

  // R9
  reload_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !irq_valid_o);
endmodule

// File: rtl/loc_irq_timer.sv
module loc_irq_timer
  import loc_irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic               load;
  logic [CNT_W-1:0]   load_val, start_q, cur;
  logic [SHIFT_W-1:0] shift_q;
  logic               tick;
  vent_t              vent_q;

  loc_irq_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cur_i(cur), .rd_data(rd_data), .load_o(load),
    .load_val_o(load_val), .start_q(start_q), .shift_q(shift_q), .vent_q(vent_q)
  );

  loc_irq_timer_prescaler #(.SW(SHIFT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear_i(load), .shift_i(shift_q), .tick_o(tick)
  );

  loc_irq_timer_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val), .start_i(start_q),
    .tick_i(tick), .vent_i(vent_q), .cur_o(cur), .irq_valid_o(irq_valid),
    .irq_vector_o(irq_vector)
  );
endmodule

// File: tb/loc_irq_timer_test.sv
module loc_irq_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  loc_irq_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a; #1;
    d = rd_data;
  endtask

  function automatic int shift_of(input logic [3:0] d);
    logic [2:0] c;
    c = {d[3], d[1:0]};
    return (c == 3'b111) ? 0 : int'(c) + 1;
  endfunction

  function automatic bit exp_irq(input int k, input int s, input int n, input bit per, input bit m);
    int d;
    if (n == 0 || m || k == 0 || (k % s) != 0) return 1'b0;
    d = k / s;
    return per ? ((d % (n + 1)) == 0) : (d == n + 1);
  endfunction

  function automatic int exp_cur(input int k, input int s, input int n, input bit per);
    int d;
    d = k / s;
    if (n == 0) return 0;
    if (per) return n - (d % (n + 1));
    return (d >= n + 1) ? 0 : n - d;
  endfunction

  // Watch the outputs each cycle from load edge t0.
  task automatic observe(input int t0, input int n, input bit per, input bit m,
                         input logic [7:0] vec, input int sh, input int window, input string req);
    int s;
    s = 1 << sh;
    rd_addr = 2'd3;
    for (int i = 0; i < window; i++) begin
      int k;
      bit ei;
      @(negedge clk);
      k = cyc - t0;
      ei = exp_irq(k, s, n, per, m);
      chk(irq_valid == ei, req, irq_valid, ei);
      if (ei) chk(irq_vector == vec, "R8", irq_vector, vec);
      chk(rd_data == 32'(exp_cur(k, s, n, per)), req, rd_data, exp_cur(k, s, n, per));
    end
  endtask

  task automatic report;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    report();
  end

  initial begin
    logic [31:0] v;
    int t0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk(v == 32'h0, "R1", v, 32'h0);
    rd(2'd1, v); chk(v == 32'h0, "R1", v, 32'h0);
    rd(2'd2, v); chk(v == 32'h0001_0000, "R1", v, 32'h0001_0000);
    rd(2'd3, v); chk(v == 32'h0, "R1", v, 32'h0);
    chk(irq_valid == 1'b0, "R1", irq_valid, 0);

    // R2 default shift 0 before any divide write
    wr(2'd2, 32'h0000_0042);
    wr(2'd0, 32'd2); t0 = cyc;
    observe(t0, 2, 1'b0, 1'b0, 8'h42, 0, 8, "R2");

    // R3/R4/R5/R6 sweep over divide codes, counts, modes
    for (int c = 0; c < 8; c++) begin
      logic [3:0] d;
      int sh;
      d = {c[2], c[0], c[1:0]};
      sh = shift_of(d);
      wr(2'd1, {28'h0, d});
      rd(2'd1, v); chk(v == {28'h0, d}, "R3", v, {28'h0, d});
      for (int p = 0; p < 2; p++) begin
        for (int ni = 0; ni < 4; ni++) begin
          int n;
          logic [7:0] vec;
          n = (ni == 3) ? 5 : ni;
          vec = 8'(8'h20 + c * 8 + ni);
          wr(2'd2, {14'h0, p[0], 1'b0, 8'h0, vec});
          wr(2'd0, 32'(n)); t0 = cyc;
          observe(t0, n, p[0], 1'b0, vec, sh, (n + 1) * (1 << sh) * 2 + 2,
                  (n == 0) ? "R6" : (p != 0 ? "R5" : "R4"));
        end
      end
    end

    // R7 mask: no pulse, count still runs
    wr(2'd1, 32'h0000_000B);
    for (int p = 0; p < 2; p++) begin
      wr(2'd2, {14'h0, p[0], 1'b1, 8'h0, 8'h99});
      wr(2'd0, 32'd3); t0 = cyc;
      observe(t0, 3, p[0], 1'b1, 8'h99, 0, 12, "R7");
    end

    // R9 reload coinciding with expiry
    wr(2'd2, {14'h0, 1'b1, 1'b0, 8'h0, 8'h77});
    wr(2'd0, 32'd2); t0 = cyc;
    while (cyc != t0 + 2) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'd4;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk(cyc == t0 + 3, "R9", cyc, t0 + 3);
    t0 = cyc;
    observe(t0, 4, 1'b1, 1'b0, 8'h77, 0, 12, "R9");

    // R10 writes to the current-count address are ignored
    wr(2'd2, 32'h0000_0011);
    wr(2'd0, 32'd1); t0 = cyc;
    observe(t0, 1, 1'b0, 1'b0, 8'h11, 0, 5, "R10");
    wr(2'd3, 32'h0000_0055);
    @(negedge clk);
    rd_addr = 2'd3; #1;
    chk(rd_data == 32'h0, "R10", rd_data, 0);
    chk(irq_valid == 1'b0, "R10", irq_valid, 0);
    rd(2'd0, v); chk(v == 32'd1, "R10", v, 1);
    rd(2'd1, v); chk(v == 32'hB, "R10", v, 32'hB);
    rd(2'd2, v); chk(v == 32'h11, "R10", v, 32'h11);

    report();
  end
endmodule